// File: doc/BRIEF.md
# Instruction Refill Signature Checker

This block sits on the instruction-cache refill path, between the memory interface and the cache arrays. Each refill burst begins with one signature word, followed by the instruction words of one cache line. By default a line is sixteen 32-bit words (64 bytes). The block keeps the signature word to itself and passes only the instruction words on to the cache. It passes them on as they arrive, without waiting for the result of the check.

As each instruction word is handed over, the block folds it into a multiple-input signature register (MISR). The register's feedback taps come from a secret key input. The cycle after the last instruction word is accepted, the block pulses `chk_done` for one cycle. At the same time it raises either `chk_pass`, when the compacted value equals the stored signature, or `chk_violation`, when it does not.

A line is started with `fill_start`. This strobe also aborts any partial line still in progress. The `fill_is_miss` qualifier, sampled with the strobe, decides whether the line is checked. Lines that are not demand-miss refills still have their signature word stripped, but they produce no verdict.

Top module: `line_sig_checker`

## Requirements
- R1: After reset, and until the first `fill_start`, `in_ready` and `out_valid` are 0 and `chk_done`, `chk_pass` and `chk_violation` are 0.
- R2: The first word accepted after `fill_start` is the signature. In that slot `in_ready` equals 1 whatever `out_ready` is, and `out_valid` stays 0, so the signature is never passed to the cache.
- R3: Each of the 16 instruction-word slots behaves as follows: `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and `out_data` equals `in_data`. A word moves on a cycle where both `in_valid` and `in_ready` are 1.
- R4: The MISR is loaded with the seed 0 at `fill_start`. On each instruction word that moves, it takes the next value m' = (m << 1) XOR (m[31] ? key : 0) XOR word, where bit 31 is the MSB.
- R5: A cycle in which no word moves leaves the MISR unchanged. The verdict of a line therefore does not depend on where stalls fall on either side.
- R6: `chk_done` is high for exactly the one cycle that follows the cycle in which the 16th instruction word moved.
- R7: When `chk_done` is high, exactly one of `chk_pass` (MISR equals signature) and `chk_violation` (they differ) is high. Both are 0 whenever `chk_done` is 0.
- R8: A line started with `fill_is_miss` = 0 is stripped and forwarded as in R2 and R3, but it produces no `chk_done`, `chk_pass` or `chk_violation`.
- R9: In the cycle where `fill_start` is 1, `in_ready` and `out_valid` are 0. A partial line cut short by `fill_start` produces no verdict, and the next word accepted is treated as a new signature.
- R10: Once the 16th instruction word has moved, `in_ready` and `out_valid` stay 0 until the next `fill_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_start | input | 1 | Starts a refill line; aborts any line in progress |
| fill_is_miss | input | 1 | Sampled with `fill_start`; 1 means the line is checked |
| key | input | 32 | Secret MISR feedback taps, held stable during a line |
| in_valid | input | 1 | Refill word valid from memory |
| in_ready | output | 1 | Refill word accepted |
| in_data | input | 32 | Refill word (signature, then instructions) |
| out_valid | output | 1 | Instruction word valid towards the cache |
| out_ready | input | 1 | Cache can take a word |
| out_data | output | 32 | Instruction word towards the cache |
| chk_done | output | 1 | One-cycle pulse when a checked line completes |
| chk_pass | output | 1 | Signature matched (valid with `chk_done`) |
| chk_violation | output | 1 | Signature mismatched (valid with `chk_done`) |

## Verification
The handshake results (`in_ready`, `out_valid`, `out_data`) are combinational from the inputs of the same cycle. The bench therefore drives on the falling edge and samples one nanosecond later, before the rising edge that moves the word. The verdict appears one rising edge after the final word moves. It is checked at the falling edge right after that transfer, and at the next falling edge the pulse is checked to be gone. Expected signatures come from a bench-side MISR model that is run over the same words. The out_ready and in_valid stall patterns vary from line to line, so every verdict also shows that stalls did not disturb the compaction.

// File: rtl/line_sig_pkg.sv
package line_sig_pkg;

   // Feedback structure of the compaction register.
   typedef enum logic [0:0] {
      MISR_INTERNAL_XOR = 1'b0,   // taps XOR into the shifted state
      MISR_EXTERNAL_XOR = 1'b1    // parity of tapped bits enters at LSB
   } misr_form_e;

   function automatic int unsigned slot_bits(input int unsigned words);
      return $clog2(words + 1);
   endfunction

endpackage

// File: rtl/sig_slot_ctrl.sv
module sig_slot_ctrl
   import line_sig_pkg::*;
#(
   parameter int unsigned WORDS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fill_start,
   input  logic fill_is_miss,
   input  logic xfer,
   output logic active,
   output logic sig_slot,
   output logic last_slot,
   output logic chk_en
);

   localparam int unsigned CW = slot_bits(WORDS);
   localparam logic [CW-1:0] LAST = CW'(WORDS);

   logic [CW-1:0] slot_q;
   logic          active_q;
   logic          chk_q;

   generate
      if (WORDS < 1) begin : g_bad_words
         $error("sig_slot_ctrl: WORDS must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q   <= '0;
         active_q <= 1'b0;
         chk_q    <= 1'b0;
      end else if (fill_start) begin
         slot_q   <= '0;
         active_q <= 1'b1;
         chk_q    <= fill_is_miss;
      end else if (xfer && active_q) begin
         if (slot_q == LAST) begin
            slot_q   <= '0;
            active_q <= 1'b0;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign active    = active_q;
   assign sig_slot  = active_q && (slot_q == '0);
   assign last_slot = active_q && (slot_q == LAST);
   assign chk_en    = chk_q;

   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill_start |=> (active && sig_slot));

   p_idle_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && last_slot && !fill_start) |=> !active);

   p_slot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer && !fill_start) |=> $stable(slot_q));

endmodule

// File: rtl/sig_misr.sv
module sig_misr
   import line_sig_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] SEED = '0,
   parameter misr_form_e FORM = MISR_INTERNAL_XOR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [DATA_W-1:0] taps,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] state,
   output logic [DATA_W-1:0] nxt
);

   logic [DATA_W-1:0] state_q;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("sig_misr: DATA_W must be at least 2");
      end
      if (FORM == MISR_INTERNAL_XOR) begin : g_internal
         always_comb begin
            nxt = {state_q[DATA_W-2:0], 1'b0} ^ din;
            if (state_q[DATA_W-1]) nxt = nxt ^ taps;
         end
      end else begin : g_external
         logic fb;
         always_comb begin
            fb  = ^(state_q & taps);
            nxt = {state_q[DATA_W-2:0], fb} ^ din;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state_q <= SEED;
      else if (load) state_q <= SEED;
      else if (step) state_q <= nxt;
   end

   assign state = state_q;

   p_seed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (state == SEED));

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(state));

endmodule

// File: rtl/sig_verdict.sv
module sig_verdict #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sig_we,
   input  logic [DATA_W-1:0] sig_in,
   input  logic              fire,
   input  logic [DATA_W-1:0] misr_final,
   output logic              done,
   output logic              pass,
   output logic              violation
);

   logic [DATA_W-1:0] sig_q;
   logic done_q, pass_q, viol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sig_q <= '0;
      else if (sig_we) sig_q <= sig_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         pass_q <= 1'b0;
         viol_q <= 1'b0;
      end else begin
         done_q <= fire;
         pass_q <= fire && (misr_final == sig_q);
         viol_q <= fire && (misr_final != sig_q);
      end
   end

   assign done      = done_q;
   assign pass      = pass_q;
   assign violation = viol_q;

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_verdict_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pass || violation) |-> done);

   p_verdict_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $onehot({pass, violation}));

endmodule

// File: rtl/line_sig_checker.sv
module line_sig_checker
   import line_sig_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 16,
   parameter logic [DATA_W-1:0] SEED = '0,
   parameter misr_form_e FORM = MISR_INTERNAL_XOR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_start,
   input  logic              fill_is_miss,
   input  logic [DATA_W-1:0] key,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              chk_done,
   output logic              chk_pass,
   output logic              chk_violation
);

   logic active, sig_slot, last_slot, chk_en;
   logic open_slot, xfer, step, sig_we, fire;
   logic [DATA_W-1:0] misr_state, misr_nxt;

   sig_slot_ctrl #(.WORDS(WORDS)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_start   (fill_start),
      .fill_is_miss (fill_is_miss),
      .xfer         (xfer),
      .active       (active),
      .sig_slot     (sig_slot),
      .last_slot    (last_slot),
      .chk_en       (chk_en)
   );

   assign open_slot = active && !fill_start;
   assign in_ready  = open_slot && (sig_slot || out_ready);
   assign out_valid = open_slot && !sig_slot && in_valid;
   assign out_data  = in_data;

   assign xfer   = in_valid && in_ready;
   assign sig_we = xfer && sig_slot;
   assign step   = xfer && !sig_slot;
   assign fire   = step && last_slot && chk_en;

   sig_misr #(.DATA_W(DATA_W), .SEED(SEED), .FORM(FORM)) u_misr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (fill_start),
      .step  (step),
      .taps  (key),
      .din   (in_data),
      .state (misr_state),
      .nxt   (misr_nxt)
   );

   sig_verdict #(.DATA_W(DATA_W)) u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .sig_we     (sig_we),
      .sig_in     (in_data),
      .fire       (fire),
      .misr_final (misr_nxt),
      .done       (chk_done),
      .pass       (chk_pass),
      .violation  (chk_violation)
   );

   p_sig_stripped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sig_slot |-> !out_valid);

   p_fwd_handshake_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready) |-> in_ready);

   p_no_check_on_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !chk_en && !fill_start) |=> !chk_done);

   p_misr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer && !fill_start) |=> $stable(misr_state));

endmodule

// File: tb/sim_line_sig_checker.sv
`timescale 1ns/1ps
module sim_line_sig_checker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_start = 1'b0;
   logic        fill_is_miss = 1'b0;
   logic [31:0] key = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_data;
   logic        chk_done, chk_pass, chk_violation;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [31:0] rng = 32'h1234_5678;
   logic [31:0] wds [16];

   always #2 clk = ~clk;   // 250 MHz

   line_sig_checker u0 (
      .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_is_miss(fill_is_miss),
      .key(key), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .chk_done(chk_done), .chk_pass(chk_pass), .chk_violation(chk_violation)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] nrand(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   // R4 model: seed 0, shift left, XOR key when the MSB was set, XOR word.
   function automatic logic [31:0] model_sig(input logic [31:0] k);
      logic [31:0] m = '0;
      for (int i = 0; i < 16; i++) begin
         logic msb = m[31];
         m = (m << 1) ^ wds[i];
         if (msb) m = m ^ k;
      end
      return m;
   endfunction

   task automatic fill_words();
      for (int i = 0; i < 16; i++) begin
         rng = nrand(rng);
         wds[i] = rng;
      end
   endtask

   task automatic begin_line(input bit miss);
      @(negedge clk);
      fill_start = 1'b1; fill_is_miss = miss; in_valid = 1'b1; out_ready = 1'b1;
      #1;
      chk(in_ready == 1'b0 && out_valid == 1'b0, "R9 strobe cycle idle", {in_ready, out_valid}, 0);
      @(negedge clk);
      fill_start = 1'b0; in_valid = 1'b0;
   endtask

   // Sends signature + 16 words with a stall pattern; checks handshake and verdict.
   task automatic run_line(input logic [31:0] sig, input int mode, input bit miss, input bit exp_pass);
      int idx = 0;
      int cyc = 0;
      begin_line(miss);
      while (idx < 17) begin
         bit iv, orr, moved;
         rng = nrand(rng);
         iv  = (mode == 2) ? (cyc % 3 != 2) : (mode == 3) ? rng[3] : 1'b1;
         orr = (mode == 1) ? (cyc % 2 == 0) : (mode == 3) ? rng[7] : 1'b1;
         if (idx == 0) orr = (mode != 0) ? 1'b0 : 1'b1;
         in_valid = iv; out_ready = orr;
         in_data = (idx == 0) ? sig : wds[idx-1];
         #1;
         if (idx == 0) begin
            chk(in_ready == 1'b1 && out_valid == 1'b0, "R2 signature slot", {in_ready, out_valid}, 2);
         end else begin
            chk(out_valid == iv && in_ready == orr, "R3 handshake", {in_ready, out_valid}, {orr, iv});
            if (out_valid) chk(out_data == wds[idx-1], "R3 data", out_data, wds[idx-1]);
         end
         chk(chk_done == 1'b0, "R6 no early done", chk_done, 0);
         moved = iv && in_ready;
         @(negedge clk);
         if (moved) idx++;
         cyc++;
      end
      in_valid = 1'b1; out_ready = 1'b1;
      #1;
      chk(chk_done == miss, "R6 done pulse", chk_done, miss);
      if (miss) begin
         chk(chk_pass == exp_pass, "R7 pass", chk_pass, exp_pass);
         chk(chk_violation == !exp_pass, "R7 violation", chk_violation, !exp_pass);
      end else begin
         chk(chk_pass == 0 && chk_violation == 0, "R8 no verdict on non-miss", {chk_pass, chk_violation}, 0);
      end
      chk(in_ready == 0 && out_valid == 0, "R10 idle after line", {in_ready, out_valid}, 0);
      @(negedge clk);
      #1;
      chk(chk_done == 0 && chk_pass == 0 && chk_violation == 0, "R6 single-cycle pulse",
          {chk_done, chk_pass, chk_violation}, 0);
      chk(in_ready == 0, "R10 still idle", in_ready, 0);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      repeat (3) @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b1;
      #1;
      chk(in_ready == 0 && out_valid == 0 && chk_done == 0 && chk_pass == 0 && chk_violation == 0,
          "R1 reset state", {in_ready, out_valid, chk_done, chk_pass, chk_violation}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(in_ready == 0 && out_valid == 0, "R1 idle before first line", {in_ready, out_valid}, 0);
      in_valid = 1'b0;

      // R4 R5: several keys and stall patterns, correct signature.
      for (int k = 0; k < 8; k++) begin
         rng = nrand(rng);
         key = (k == 0) ? 32'h0000_0000 : (k == 1) ? 32'hFFFF_FFFF : rng;
         for (int mode = 0; mode < 4; mode++) begin
            fill_words();
            run_line(model_sig(key), mode, 1'b1, 1'b1);
         end
      end

      // R7: every single-bit signature error is flagged.
      key = 32'h04C1_1DB7;
      fill_words();
      s = model_sig(key);
      for (int b = 0; b < 32; b++) begin
         run_line(s ^ (32'h1 << b), b % 4, 1'b1, 1'b0);
      end

      // R4: a key difference changes the verdict for words that reach the taps.
      for (int i = 0; i < 16; i++) wds[i] = 32'h8000_0000;
      s = model_sig(32'h0000_0001);
      key = 32'h0000_0003;
      run_line(s, 0, 1'b1, (model_sig(32'h0000_0003) == s));

      // R8: non-miss lines produce no verdict.
      key = 32'hA5A5_0F0F;
      fill_words();
      run_line(model_sig(key), 1, 1'b0, 1'b1);
      fill_words();
      run_line(32'hDEAD_BEEF, 3, 1'b0, 1'b0);

      // R9: abort a partial line, then a full line passes once.
      fill_words();
      begin_line(1'b1);
      in_valid = 1'b1; out_ready = 1'b1; in_data = 32'h1111_2222;
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         in_data = wds[i];
      end
      #1;
      chk(chk_done == 0, "R9 no verdict mid-line", chk_done, 0);
      in_valid = 1'b0;
      fill_words();
      run_line(model_sig(key), 2, 1'b1, 1'b1);
      // R9: abort one word before the end.
      begin_line(1'b1);
      in_valid = 1'b1; in_data = model_sig(key);
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         in_data = wds[i];
      end
      @(negedge clk);
      in_valid = 1'b0;
      fill_words();
      run_line(model_sig(key), 0, 1'b1, 1'b1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule